// File: doc/BRIEF.md
# ADC Power-Mode State Controller

This block models the power management of a sampling converter. A 2-bit power-mode field, loaded by a register write, selects one of four policies: stay powered, sleep fully after every conversion, sleep in standby after every conversion, or power down at once and stay down until the mode is rewritten. The controller tracks the power state and the track-and-hold state. It times the power-up interval after each wake and raises a ready flag once a conversion may start.

The write strobe and the conversion-start input may be asynchronous. Each passes through a two-flop synchronizer and then a rising-edge detector. The controller acts on the third clock edge after an input rises. The end-of-conversion pulse is synchronous and lasts one cycle. Power-up delays are parameters counted in clock cycles. The defaults are sized for a 250 MHz clock. A conversion start that arrives before the part is ready sets a sticky invalid flag. The next register write clears that flag.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After reset the mode is normal (00), `pwr_state` is ON (00), `tracking` is 0 (hold), `ready` is 1 and `invalid_conv` is 0.
- R2: In normal mode a rising edge of `conv_start` sets `tracking` to 1, and `ready` stays 1.
- R3: In mode 01 (auto-shutdown) an `eoc` pulse while ready moves `pwr_state` to SHUTDOWN (10) and `tracking` to 0. The next `conv_start` rise returns it to ON with `tracking` 1. `ready` then rises exactly FULL_UP_CYC cycles later, whatever the value of `ref_internal`.
- R4: In mode 10 (auto-standby) an `eoc` pulse while ready moves `pwr_state` to STANDBY (01) and `tracking` to 0. The next `conv_start` rise wakes it to ON with `tracking` 1. `ready` then rises INT_UP_CYC cycles later when `ref_internal` is 1, or EXT_UP_CYC cycles later when it is 0.
- R5: A write of mode 11 (full shutdown) moves `pwr_state` to SHUTDOWN, `tracking` to 0 and `ready` to 0. While the mode stays 11, `conv_start` rises leave `pwr_state` and `tracking` unchanged.
- R6: A write of any mode other than 11 while the mode is 11 sets `pwr_state` to ON and `tracking` to 1 on that write. `ready` then rises FULL_UP_CYC cycles later.
- R7: The mode field is kept through sleep. After an auto-standby wake, the next `eoc` puts the block back into STANDBY without another write.
- R8: A `conv_start` rise that is not a wake event and arrives while `ready` is 0 sets `invalid_conv`. The flag stays set until the next register write clears it.
- R9: In normal mode `eoc` has no effect on `pwr_state`, `tracking` or `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_strobe | input | 1 | Register write strobe; the write takes effect on its rising edge |
| wr_data | input | 2 | Power-mode field to write (00 normal, 01 auto-shutdown, 10 auto-standby, 11 full shutdown) |
| conv_start | input | 1 | Conversion-start request; acted on at its rising edge |
| eoc | input | 1 | One-cycle end-of-conversion pulse |
| ref_internal | input | 1 | 1 selects the internal reference for the standby wake delay |
| pwr_state | output | 2 | 00 ON, 01 STANDBY, 10 SHUTDOWN |
| tracking | output | 1 | 1 when the track-and-hold tracks, 0 when it holds |
| ready | output | 1 | 1 when powered and the power-up interval has elapsed |
| invalid_conv | output | 1 | Sticky flag for a conversion start made while not ready |

## Verification
The assertions assume that `wr_data` is stable whenever `wr_strobe` is high. They also assume that `eoc` arrives only as a single-cycle pulse, and that a write, a conversion-start edge and an end-of-conversion pulse never reach the controller in the same cycle. The stimulus keeps to these assumptions in several ways. It sets the data one cycle before raising the strobe and holds it until after the strobe falls. It drives each strobe for four cycles and then idles it for four more, so no two detected edges coincide. It pulses `eoc` for a single cycle while both strobes are low.

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl #(
  parameter int FULL_UP_CYC = 2_500_000,
  parameter int INT_UP_CYC  = 1750,
  parameter int EXT_UP_CYC  = 150
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_strobe,
  input  logic [1:0] wr_data,
  input  logic       conv_start,
  input  logic       eoc,
  input  logic       ref_internal,
  output logic [1:0] pwr_state,
  output logic       tracking,
  output logic       ready,
  output logic       invalid_conv
);
  localparam int MAX_A = (FULL_UP_CYC > INT_UP_CYC) ? FULL_UP_CYC : INT_UP_CYC;
  localparam int MAX_C = (MAX_A > EXT_UP_CYC) ? MAX_A : EXT_UP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  localparam logic [1:0] M_NORM = 2'b00, M_ASHD = 2'b01, M_ASTB = 2'b10, M_FSHD = 2'b11;
  localparam logic [1:0] P_ON = 2'b00, P_STBY = 2'b01, P_SHDN = 2'b10;

  logic [2:0]    wr_sy, cv_sy;
  logic          wr_rise, cv_rise;
  logic [1:0]    mode;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sy <= '0;
      cv_sy <= '0;
    end else begin
      wr_sy <= {wr_sy[1:0], wr_strobe};
      cv_sy <= {cv_sy[1:0], conv_start};
    end
  end

  assign wr_rise = wr_sy[1] & ~wr_sy[2];
  assign cv_rise = cv_sy[1] & ~cv_sy[2];
  assign ready   = (pwr_state == P_ON) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode         <= M_NORM;
      pwr_state    <= P_ON;
      tracking     <= 1'b0;
      cnt          <= '0;
      invalid_conv <= 1'b0;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (wr_rise) begin
        mode         <= wr_data;
        invalid_conv <= 1'b0;
        if (wr_data == M_FSHD) begin
          pwr_state <= P_SHDN;
          tracking  <= 1'b0;
          cnt       <= '0;
        end else if (mode == M_FSHD) begin
          pwr_state <= P_ON;
          tracking  <= 1'b1;
          cnt       <= CW'(FULL_UP_CYC);
        end
      end else if (cv_rise) begin
        if (pwr_state != P_ON && mode != M_FSHD) begin
          pwr_state <= P_ON;
          tracking  <= 1'b1;
          if (pwr_state == P_SHDN) cnt <= CW'(FULL_UP_CYC);
          else if (ref_internal)   cnt <= CW'(INT_UP_CYC);
          else                     cnt <= CW'(EXT_UP_CYC);
        end else begin
          if (!ready) invalid_conv <= 1'b1;
          if (pwr_state == P_ON) tracking <= 1'b1;
        end
      end else if (eoc && ready) begin
        if (mode == M_ASHD) begin
          pwr_state <= P_SHDN;
          tracking  <= 1'b0;
        end else if (mode == M_ASTB) begin
          pwr_state <= P_STBY;
          tracking  <= 1'b0;
        end
      end
    end
  end
endmodule

module adc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eoc,
  input logic       wr_rise,
  input logic       cv_rise,
  input logic [1:0] mode,
  input logic [1:0] pwr_state,
  input logic       tracking,
  input logic       ready,
  input logic       invalid_conv
);
  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state != 2'b11);
  a_r3_eoc_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && ready && mode == 2'b01 && !wr_rise && !cv_rise) |=> (pwr_state == 2'b10 && !tracking));
  a_r4_eoc_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && ready && mode == 2'b10 && !wr_rise && !cv_rise) |=> (pwr_state == 2'b01 && !tracking));
  a_r4_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != 2'b00) |-> (!tracking && !ready));
  a_r5_full_stays_down: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10 && mode == 2'b11 && !wr_rise) |=> (pwr_state == 2'b10 && !tracking));
  a_r8_invalid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (invalid_conv && !wr_rise) |=> invalid_conv);
  a_r8_invalid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> !invalid_conv);
  a_r9_normal_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && mode == 2'b00 && pwr_state == 2'b00 && !wr_rise && !cv_rise) |=> (pwr_state == 2'b00 && $stable(tracking)));
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eoc(eoc), .wr_rise(wr_rise), .cv_rise(cv_rise),
  .mode(mode), .pwr_state(pwr_state), .tracking(tracking), .ready(ready),
  .invalid_conv(invalid_conv)
);

// File: tb/test_adc_pwr_ctrl.sv
module test_adc_pwr_ctrl;
  localparam int FULL = 60, INTC = 30, EXTC = 12;
  localparam logic [1:0] OP_WR = 0, OP_CV = 1, OP_EOC = 2, OP_WAIT = 3;
  // {op, data, ref, exp_state, exp_track, exp_ready}
  localparam logic [8:0] VEC [15] = '{
    {OP_CV,   2'b00, 1'b0, 2'b00, 1'b1, 1'b1},  // R2
    {OP_EOC,  2'b00, 1'b0, 2'b00, 1'b1, 1'b1},  // R9
    {OP_WR,   2'b01, 1'b0, 2'b00, 1'b1, 1'b1},
    {OP_EOC,  2'b00, 1'b0, 2'b10, 1'b0, 1'b0},  // R3
    {OP_CV,   2'b00, 1'b0, 2'b00, 1'b1, 1'b0},  // R3
    {OP_WAIT, 2'b00, 1'b0, 2'b00, 1'b1, 1'b1},
    {OP_WR,   2'b10, 1'b1, 2'b00, 1'b1, 1'b1},
    {OP_EOC,  2'b00, 1'b1, 2'b01, 1'b0, 1'b0},  // R4
    {OP_CV,   2'b00, 1'b1, 2'b00, 1'b1, 1'b0},  // R4
    {OP_WAIT, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1},
    {OP_EOC,  2'b00, 1'b1, 2'b01, 1'b0, 1'b0},  // R7
    {OP_WR,   2'b11, 1'b1, 2'b10, 1'b0, 1'b0},  // R5
    {OP_CV,   2'b00, 1'b1, 2'b10, 1'b0, 1'b0},  // R5
    {OP_WR,   2'b00, 1'b1, 2'b00, 1'b1, 1'b0},  // R6
    {OP_WAIT, 2'b00, 1'b1, 2'b00, 1'b1, 1'b1}
  };

  logic clk = 0, rst_n = 0, wr_strobe = 0, conv_start = 0, eoc = 0, ref_internal = 0;
  logic [1:0] wr_data = 0;
  logic [1:0] pwr_state;
  logic tracking, ready, invalid_conv;
  int checks = 0, fails = 0, cycles = 0, k;

  always #2 clk = ~clk;

  adc_pwr_ctrl #(.FULL_UP_CYC(FULL), .INT_UP_CYC(INTC), .EXT_UP_CYC(EXTC)) i_adc_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .conv_start(conv_start), .eoc(eoc), .ref_internal(ref_internal),
    .pwr_state(pwr_state), .tracking(tracking), .ready(ready), .invalid_conv(invalid_conv));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_wr(input logic [1:0] d);
    wr_data = d; idle(1);
    wr_strobe = 1; idle(4);
    wr_strobe = 0; idle(4);
  endtask

  task automatic do_cv();
    conv_start = 1; idle(4);
    conv_start = 0; idle(4);
  endtask

  task automatic do_eoc();
    eoc = 1; idle(1);
    eoc = 0; idle(1);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 200 && !ready; i++) idle(1);
  endtask

  // starts a wake through a write (is_wr) or a conversion start, returns cycles to ready
  task automatic measure(input bit is_wr, input logic [1:0] d, output int n);
    wr_data = d; idle(1);
    if (is_wr) wr_strobe = 1; else conv_start = 1;
    for (int i = 0; i < 20 && !tracking; i++) idle(1);
    n = 0;
    while (!ready && n < 500) begin idle(1); n++; end
    wr_strobe = 0; conv_start = 0; idle(4);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1; idle(1);
    check("R1 state", pwr_state, 0);
    check("R1 tracking", tracking, 0);
    check("R1 ready", ready, 1);
    check("R1 invalid", invalid_conv, 0);

    foreach (VEC[i]) begin
      logic [8:0] v;
      v = VEC[i];
      ref_internal = v[4];
      case (v[8:7])
        OP_WR:   do_wr(v[6:5]);
        OP_CV:   do_cv();
        OP_EOC:  do_eoc();
        default: wait_ready();
      endcase
      check($sformatf("vector %0d state (R2-R9 table)", i), pwr_state, v[3:2]);
      check($sformatf("vector %0d tracking", i), tracking, v[1]);
      check($sformatf("vector %0d ready", i), ready, v[0]);
    end

    // R3: shutdown wake time independent of the reference
    do_wr(2'b01); do_eoc();
    ref_internal = 1; measure(0, 2'b01, k); check("R3 wake delay int ref", k, FULL);
    do_eoc();
    ref_internal = 0; measure(0, 2'b01, k); check("R3 wake delay ext ref", k, FULL);

    // R4 and R7: standby wake time follows the reference
    do_wr(2'b10); do_eoc();
    check("R4 standby entered", pwr_state, 1);
    ref_internal = 1; measure(0, 2'b10, k); check("R4 wake delay int ref", k, INTC);
    do_eoc();
    check("R7 mode retained", pwr_state, 1);
    ref_internal = 0; measure(0, 2'b10, k); check("R4 wake delay ext ref", k, EXTC);

    // R6: write-driven wake from full shutdown
    do_wr(2'b11);
    check("R5 ready low", ready, 0);
    measure(1, 2'b00, k); check("R6 wake delay", k, FULL);

    // R8: early conversion start during power-up
    do_wr(2'b11);
    wr_data = 2'b00; idle(1); wr_strobe = 1; idle(4); wr_strobe = 0; idle(4);
    check("R6 tracking after write", tracking, 1);
    check("R8 flag clear before", invalid_conv, 0);
    do_cv();
    check("R8 flag set", invalid_conv, 1);
    wait_ready();
    check("R8 flag sticky", invalid_conv, 1);
    do_cv();
    check("R8 ready unaffected", ready, 1);
    do_wr(2'b00);
    check("R8 flag cleared by write", invalid_conv, 0);

    // R5: conversion start in full shutdown does not set state
    do_wr(2'b11); do_cv();
    check("R5 still down", pwr_state, 2);
    check("R5 still holding", tracking, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule